// File: doc/BRIEF.md
# Four-Plane Tile Raster Unit

This unit sits between a CPU bus and a planar frame store that keeps four bit planes side by side: plane 0 (blue), plane 1 (red), plane 2 (green) and plane 3 (extra). It speeds up drawing. Each plane has its own 8-bit tile colour register. A mode register selects the behaviour and can remove single planes from an access. One CPU write can update every selected plane at once. It does so either by stamping the tile colours or by blending them in under a CPU-supplied pixel mask. One CPU read can return a byte that marks the pixels whose selected planes all carry the tile colour.

The plane store is an external synchronous RAM. It has one 32-bit word per offset, one byte lane per plane and a lane-write mask. Read data returns one cycle after the read strobe. Accesses are bytes or 16-bit words, and either of two display pages can be addressed. A multi-step access keeps `busy` high until its last plane update, so the read, merge and write of a blend can never be split by another CPU access. Every byte written is reported on a dirty strobe for the display side. A sticky per-page "display changed" flag is also set, and it stays set until the display side acknowledges it.

Top module: `tile_raster_unit`

## Requirements
- R1: After reset, busy, rvalid, mem_re, mem_we, dirty_we and disp_chg are all 0, the mode register is 0x00 and all tiles are 0x00.
- R2: The mode register is written through mode_we/mode_wdata. Bits 3..0 each exclude one plane (bit p excludes plane p, and plane p sits in bits 8p+7..8p of mem_wdata/mem_rdata). Bit 7 = 1 activates the unit. With bit 7 = 1, bit 6 = 0 selects tile-stamp writes with compare reads (mode 0x80), and bit 6 = 1 selects blend writes with plain reads (mode 0xC0). The mode must not be rewritten while busy is high.
- R3: Tile-stamp write: every included plane byte at the target becomes that plane's tile and the CPU data is ignored. Excluded planes keep their contents, so with all four planes excluded memory does not change.
- R4: Blend write: every included plane byte becomes (old AND NOT d) OR (d AND tile), where d is the CPU byte. Excluded planes are unchanged.
- R5: Compare read: each result bit is the inverse of the OR, over the included planes, of (plane byte XOR tile). With all planes excluded the result is 0xFF.
- R6: In blend mode and with the unit inactive (bit 7 = 0), a read returns the plain byte of plane cpu_addr[16:15].
- R7: With the unit inactive, a write stores the CPU byte in plane cpu_addr[16:15] only.
- R8: The plane offset is cpu_addr[14:0], and mem_addr = {cpu_page, offset}. A word access touches offset and offset+1 modulo 2^15 on the same page. cpu_wdata[7:0] and rdata[7:0] belong to the lower address. For a byte read, rdata[15:8] is 0.
- R9: Each written byte pulses dirty_we with its offset on dirty_addr and a one-hot page on dirty_pg (bit 0 for page 0, bit 1 for page 1), even when every plane is excluded. It also sets disp_chg[page], which stays 1 until disp_ack[page] clears it.
- R10: A request is taken when cpu_req is high and busy is low, and busy rises on the next cycle. Busy then stays high for 1 cycle per byte for tile-stamp and plain writes, and for 2 cycles per byte for reads and blends. rvalid pulses for one cycle, with rdata, in the first cycle in which busy is low after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register value |
| tile_we | input | 1 | Tile register write strobe |
| tile_sel | input | 2 | Plane whose tile is written |
| tile_wdata | input | 8 | Tile colour byte |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = 16-bit access |
| cpu_addr | input | 17 | Plane select [16:15] and offset [14:0] |
| cpu_page | input | 1 | Display page |
| cpu_wdata | input | 16 | Write data / pixel mask |
| busy | output | 1 | Access in progress |
| rvalid | output | 1 | Read data valid pulse |
| rdata | output | 16 | Read result |
| mem_re | output | 1 | Plane RAM read strobe |
| mem_we | output | 1 | Plane RAM write strobe |
| mem_addr | output | 16 | Plane RAM address {page, offset} |
| mem_be | output | 4 | Plane lane write mask |
| mem_wdata | output | 32 | Plane lane write data |
| mem_rdata | input | 32 | Plane lane read data, one cycle after mem_re |
| dirty_we | output | 1 | A byte was written |
| dirty_addr | output | 15 | Offset of the written byte |
| dirty_pg | output | 2 | One-hot page of the written byte |
| disp_chg | output | 2 | Sticky per-page display-changed flags |
| disp_ack | input | 2 | Per-page clear of disp_chg |

## Verification
The bench targets these corner cases:
- **Word access at offset 0x7FFF.** The second byte must wrap to offset 0 on the same page. A design that carries into the page bit would corrupt the other page.
- **Every plane excluded.** A compare read must give 0xFF and a stamp must leave memory untouched. A design that fails to gate the XOR terms would return colour data, and one that ignores the lane mask would overwrite planes.
- **Tile-stamp with random CPU data.** A unit that leaks data into a stamp would show mismatched plane bytes.
- **Blends with random masks over random old contents.** These catch a swapped merge term.
- **Busy length per access kind.** Counting busy cycles and dirty pulses catches a blend that releases the bus between its read and its write, and a word access that skips its upper byte.

// File: rtl/trp_pkg.sv
package trp_pkg;

  typedef enum logic [2:0] {
    K_PLR,   // plain read of one plane
    K_PLW,   // plain write of one plane
    K_TLW,   // tile stamp write
    K_RMW,   // masked tile blend
    K_CMP    // colour compare read
  } acc_kind_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RD,
    S_USE,
    S_WR
  } seq_state_t;

  function automatic acc_kind_t decode_kind(input logic en, input logic blend,
                                            input logic we);
    if (!en)   return we ? K_PLW : K_PLR;
    if (blend) return we ? K_RMW : K_PLR;
    return we ? K_TLW : K_CMP;
  endfunction

  function automatic logic kind_reads(input acc_kind_t k);
    return (k == K_PLR) || (k == K_RMW) || (k == K_CMP);
  endfunction

  function automatic logic kind_returns(input acc_kind_t k);
    return (k == K_PLR) || (k == K_CMP);
  endfunction

endpackage

// File: rtl/trp_rst_sync.sv
module trp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/trp_plane_alu.sv
module trp_plane_alu #(
  parameter int PLANES = 4,
  parameter int BW     = 8
) (
  input  logic [PLANES*BW-1:0] old_planes,
  input  logic [PLANES*BW-1:0] tiles,
  input  logic [BW-1:0]        data,
  input  logic [PLANES-1:0]    inh,
  output logic [PLANES*BW-1:0] merged,
  output logic [BW-1:0]        match
);
  logic [PLANES-1:0][BW-1:0] diff;
  logic [BW-1:0]             any_diff;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    assign merged[p*BW +: BW] = (old_planes[p*BW +: BW] & ~data) |
                                (data & tiles[p*BW +: BW]);
    assign diff[p] = inh[p] ? '0 : (old_planes[p*BW +: BW] ^ tiles[p*BW +: BW]);
  end

  always_comb begin
    any_diff = '0;
    for (int p = 0; p < PLANES; p++) any_diff = any_diff | diff[p];
  end

  assign match = ~any_diff;
endmodule

// File: rtl/trp_seq.sv
module trp_seq
  import trp_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int BW     = 8,
  parameter int OFS_W  = 15,
  parameter int CPU_AW = 17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            mode,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic                  cpu_word,
  input  logic [CPU_AW-1:0]     cpu_addr,
  input  logic                  cpu_page,
  input  logic [2*BW-1:0]       cpu_wdata,
  input  logic [PLANES*BW-1:0]  tiles,
  input  logic [PLANES*BW-1:0]  mem_rdata,
  input  logic [PLANES*BW-1:0]  alu_merged,
  input  logic [BW-1:0]         alu_match,
  output logic [BW-1:0]         alu_data,
  output logic [PLANES-1:0]     alu_inh,
  output logic                  busy,
  output logic                  rvalid,
  output logic [2*BW-1:0]       rdata,
  output logic                  mem_re,
  output logic                  mem_we,
  output logic [OFS_W:0]        mem_addr,
  output logic [PLANES-1:0]     mem_be,
  output logic [PLANES*BW-1:0]  mem_wdata,
  output logic                  dirty_we,
  output logic [OFS_W-1:0]      dirty_addr,
  output logic [1:0]            dirty_pg
);
  localparam int PSEL_W = $clog2(PLANES);
  localparam int DW     = 2 * BW;

  seq_state_t          state_q, state_n;
  acc_kind_t           kind_q, kind_n, kind_dec;
  logic [PLANES-1:0]   inh_q, inh_n;
  logic [PSEL_W-1:0]   psel_q, psel_n;
  logic [OFS_W-1:0]    ofs_q, ofs_n, cur_ofs;
  logic                page_q, page_n, word_q, word_n, hi_q, hi_n;
  logic [DW-1:0]       wd_q, wd_n, rdata_q, rdata_n;
  logic [BW-1:0]       lo_q, lo_n, rbyte;
  logic                rvalid_q, rvalid_n;
  logic                unused_mode;

  assign unused_mode = ^mode[5:4];
  assign kind_dec    = decode_kind(mode[7], mode[6], cpu_we);
  assign cur_ofs     = ofs_q + OFS_W'(hi_q);
  assign alu_data    = hi_q ? wd_q[DW-1:BW] : wd_q[BW-1:0];
  assign alu_inh     = inh_q;
  assign rbyte       = (kind_q == K_CMP) ? alu_match : mem_rdata[psel_q*BW +: BW];

  always_comb begin
    state_n  = state_q;
    kind_n   = kind_q;
    inh_n    = inh_q;
    psel_n   = psel_q;
    ofs_n    = ofs_q;
    page_n   = page_q;
    word_n   = word_q;
    hi_n     = hi_q;
    wd_n     = wd_q;
    lo_n     = lo_q;
    rdata_n  = rdata_q;
    rvalid_n = 1'b0;
    case (state_q)
      S_IDLE: if (cpu_req) begin
        kind_n  = kind_dec;
        inh_n   = mode[PLANES-1:0];
        psel_n  = cpu_addr[OFS_W +: PSEL_W];
        ofs_n   = cpu_addr[OFS_W-1:0];
        page_n  = cpu_page;
        word_n  = cpu_word;
        wd_n    = cpu_wdata;
        hi_n    = 1'b0;
        state_n = kind_reads(kind_dec) ? S_RD : S_WR;
      end
      S_RD: state_n = S_USE;
      default: begin
        if (kind_returns(kind_q) && !hi_q) lo_n = rbyte;
        if (word_q && !hi_q) begin
          hi_n    = 1'b1;
          state_n = kind_reads(kind_q) ? S_RD : S_WR;
        end else begin
          state_n = S_IDLE;
          if (kind_returns(kind_q)) begin
            rvalid_n = 1'b1;
            rdata_n  = word_q ? {rbyte, lo_q} : {{BW{1'b0}}, rbyte};
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      kind_q   <= K_PLR;
      inh_q    <= '0;
      psel_q   <= '0;
      ofs_q    <= '0;
      page_q   <= 1'b0;
      word_q   <= 1'b0;
      hi_q     <= 1'b0;
      wd_q     <= '0;
      lo_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      kind_q   <= kind_n;
      inh_q    <= inh_n;
      psel_q   <= psel_n;
      ofs_q    <= ofs_n;
      page_q   <= page_n;
      word_q   <= word_n;
      hi_q     <= hi_n;
      wd_q     <= wd_n;
      lo_q     <= lo_n;
      rdata_q  <= rdata_n;
      rvalid_q <= rvalid_n;
    end
  end

  always_comb begin
    case (kind_q)
      K_PLW:   mem_wdata = {PLANES{alu_data}};
      K_TLW:   mem_wdata = tiles;
      default: mem_wdata = alu_merged;
    endcase
    mem_be = (kind_q == K_PLW) ? (PLANES'(1) << psel_q) : ~inh_q;
  end

  assign busy       = (state_q != S_IDLE);
  assign mem_re     = (state_q == S_RD);
  assign mem_we     = (state_q == S_WR) || ((state_q == S_USE) && (kind_q == K_RMW));
  assign mem_addr   = {page_q, cur_ofs};
  assign dirty_we   = mem_we;
  assign dirty_addr = cur_ofs;
  assign dirty_pg   = page_q ? 2'b10 : 2'b01;
  assign rvalid     = rvalid_q;
  assign rdata      = rdata_q;
endmodule

// File: rtl/tile_raster_unit.sv
module tile_raster_unit #(
  parameter int PLANES = 4,
  parameter int BW     = 8,
  parameter int OFS_W  = 15,
  parameter int CPU_AW = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_we,
  input  logic [7:0]           mode_wdata,
  input  logic                 tile_we,
  input  logic [1:0]           tile_sel,
  input  logic [BW-1:0]        tile_wdata,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic                 cpu_word,
  input  logic [CPU_AW-1:0]    cpu_addr,
  input  logic                 cpu_page,
  input  logic [2*BW-1:0]      cpu_wdata,
  output logic                 busy,
  output logic                 rvalid,
  output logic [2*BW-1:0]      rdata,
  output logic                 mem_re,
  output logic                 mem_we,
  output logic [OFS_W:0]       mem_addr,
  output logic [PLANES-1:0]    mem_be,
  output logic [PLANES*BW-1:0] mem_wdata,
  input  logic [PLANES*BW-1:0] mem_rdata,
  output logic                 dirty_we,
  output logic [OFS_W-1:0]     dirty_addr,
  output logic [1:0]           dirty_pg,
  output logic [1:0]           disp_chg,
  input  logic [1:0]           disp_ack
);
  logic                  rst_i_n;
  logic [7:0]            mode_q, mode_n;
  logic [PLANES*BW-1:0]  tile_q, tile_n;
  logic [1:0]            disp_q, disp_n;
  logic [PLANES*BW-1:0]  alu_merged;
  logic [BW-1:0]         alu_match, alu_data;
  logic [PLANES-1:0]     alu_inh;

  trp_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  always_comb begin
    mode_n = mode_we ? mode_wdata : mode_q;
    disp_n = (disp_q & ~disp_ack) | (dirty_we ? dirty_pg : 2'b00);
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_tile
    assign tile_n[p*BW +: BW] = (tile_we && (tile_sel == 2'(p))) ? tile_wdata
                                                                 : tile_q[p*BW +: BW];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mode_q <= '0;
      tile_q <= '0;
      disp_q <= '0;
    end else begin
      mode_q <= mode_n;
      tile_q <= tile_n;
      disp_q <= disp_n;
    end
  end

  assign disp_chg = disp_q;

  trp_plane_alu #(.PLANES(PLANES), .BW(BW)) u_alu (
    .old_planes(mem_rdata), .tiles(tile_q), .data(alu_data), .inh(alu_inh),
    .merged(alu_merged), .match(alu_match)
  );

  trp_seq #(.PLANES(PLANES), .BW(BW), .OFS_W(OFS_W), .CPU_AW(CPU_AW)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .mode(mode_q),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_word(cpu_word), .cpu_addr(cpu_addr),
    .cpu_page(cpu_page), .cpu_wdata(cpu_wdata), .tiles(tile_q), .mem_rdata(mem_rdata),
    .alu_merged(alu_merged), .alu_match(alu_match), .alu_data(alu_data), .alu_inh(alu_inh),
    .busy(busy), .rvalid(rvalid), .rdata(rdata), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .dirty_we(dirty_we), .dirty_addr(dirty_addr), .dirty_pg(dirty_pg)
  );
endmodule

// File: rtl/trp_chk.sv
module trp_chk #(
  parameter int PLANES = 4
) (
  input logic              clk,
  input logic              rst_i_n,
  input logic              cpu_req,
  input logic              busy,
  input logic              rvalid,
  input logic              mem_re,
  input logic              mem_we,
  input logic [PLANES-1:0] mem_be,
  input logic [15:0]       mem_addr,
  input logic [7:0]        mode_q,
  input logic              dirty_we,
  input logic [1:0]        dirty_pg,
  input logic [1:0]        disp_chg
);
  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cpu_req && !busy) |=> busy);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> (!mem_we && !mem_re));
  // R10
  read_then_use_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_re |=> (busy && !mem_re));
  // R10
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rvalid |=> !rvalid);
  // R3
  excluded_lane_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_we && mode_q[7]) |-> ((mem_be & mode_q[PLANES-1:0]) == '0));
  // R9
  dirty_page_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    dirty_we |-> $onehot(dirty_pg));
  // R9
  disp_set_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_we && !mem_addr[15]) |=> disp_chg[0]);
endmodule

bind tile_raster_unit trp_chk #(.PLANES(PLANES)) u_chk (
  .clk(clk), .rst_i_n(rst_i_n), .cpu_req(cpu_req), .busy(busy), .rvalid(rvalid),
  .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
  .mode_q(mode_q), .dirty_we(dirty_we), .dirty_pg(dirty_pg), .disp_chg(disp_chg)
);

// File: tb/tile_raster_unit_test.sv
`timescale 1ns/1ps
module tile_raster_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 0, tile_we = 0, cpu_req = 0, cpu_we = 0, cpu_word = 0, cpu_page = 0;
  logic [7:0]  mode_wdata = 0, tile_wdata = 0;
  logic [1:0]  tile_sel = 0, disp_ack = 0;
  logic [16:0] cpu_addr = 0;
  logic [15:0] cpu_wdata = 0;
  logic        busy, rvalid, mem_re, mem_we, dirty_we;
  logic [15:0] rdata, mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic [14:0] dirty_addr;
  logic [1:0]  dirty_pg, disp_chg;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_q = 0;
  logic [7:0] t_q [4] = '{default: 8'h00};
  logic [31:0] ram [int];

  always #2.5 clk = ~clk;

  tile_raster_unit uut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .tile_we(tile_we), .tile_sel(tile_sel), .tile_wdata(tile_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_word(cpu_word), .cpu_addr(cpu_addr),
    .cpu_page(cpu_page), .cpu_wdata(cpu_wdata), .busy(busy), .rvalid(rvalid),
    .rdata(rdata), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dirty_we(dirty_we), .dirty_addr(dirty_addr), .dirty_pg(dirty_pg),
    .disp_chg(disp_chg), .disp_ack(disp_ack)
  );

  function automatic logic [31:0] init_val(int a);
    return a * 32'h2545F491 + 32'h6A09E667;
  endfunction

  function automatic logic [31:0] get(int a);
    return ram.exists(a) ? ram[a] : init_val(a);
  endfunction

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= get(int'(mem_addr));
    if (mem_we) begin
      logic [31:0] w;
      w = get(int'(mem_addr));
      for (int p = 0; p < 4; p++) if (mem_be[p]) w[p*8 +: 8] = mem_wdata[p*8 +: 8];
      ram[int'(mem_addr)] = w;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [7:0] m);
    @(negedge clk); mode_we = 1; mode_wdata = m;
    @(negedge clk); mode_we = 0; m_q = m;
  endtask

  task automatic set_tile(input int p, input logic [7:0] v);
    @(negedge clk); tile_we = 1; tile_sel = 2'(p); tile_wdata = v;
    @(negedge clk); tile_we = 0; t_q[p] = v;
  endtask

  // Issue one access, count busy cycles, check dirty strobes (R9, R8) and rvalid (R10)
  task automatic do_acc(input bit we, input bit word, input logic [16:0] addr,
                        input bit pg, input logic [15:0] wd,
                        output logic [15:0] rd, output int nb);
    int nd;
    nd = 0; nb = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_word = word; cpu_addr = addr; cpu_page = pg; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0;
    while (busy && nb < 20) begin
      nb++;
      if (dirty_we) begin
        check(dirty_addr == 15'(addr[14:0] + 15'(nd)), "R8 dirty offset", 32'(dirty_addr),
              32'(15'(addr[14:0] + 15'(nd))));
        check(dirty_pg == (pg ? 2'b10 : 2'b01), "R9 dirty page", 32'(dirty_pg),
              pg ? 32'd2 : 32'd1);
        nd++;
      end
      @(negedge clk);
    end
    rd = rdata;
    check(rvalid == !we, "R10 rvalid pulse", 32'(rvalid), 32'(!we));
    check(nd == (we ? (word ? 2 : 1) : 0), "R9 dirty count", 32'(nd),
          32'(we ? (word ? 2 : 1) : 0));
  endtask

  // Compute expectation from the requirements, run, compare
  task automatic run(input bit we, input bit word, input logic [16:0] addr,
                     input bit pg, input logic [15:0] wd);
    int n, a[2], nb, lat;
    logic [31:0] expw[2];
    logic [7:0] rb[2];
    logic [15:0] rd, exprd;
    logic [3:0] inh;
    int psel;
    string tag;
    n = word ? 2 : 1;
    inh = m_q[3:0];
    psel = int'(addr[16:15]);
    lat = 0;
    for (int k = 0; k < n; k++) begin
      logic [31:0] old;
      logic [7:0] d, acc;
      a[k] = int'({pg, 15'(addr[14:0] + 15'(k))});
      old = get(a[k]);
      d = k ? wd[15:8] : wd[7:0];
      expw[k] = old;
      acc = 8'h00;
      if (!m_q[7]) begin
        tag = we ? "R7" : "R6";
        if (we) expw[k][psel*8 +: 8] = d;
        rb[k] = old[psel*8 +: 8];
        lat += we ? 1 : 2;
      end else if (m_q[6]) begin
        tag = we ? "R4" : "R6";
        for (int p = 0; p < 4; p++)
          if (!inh[p]) expw[k][p*8 +: 8] = (old[p*8 +: 8] & ~d) | (d & t_q[p]);
        rb[k] = old[psel*8 +: 8];
        lat += 2;
      end else begin
        tag = we ? "R3" : "R5";
        for (int p = 0; p < 4; p++)
          if (!inh[p]) begin
            expw[k][p*8 +: 8] = t_q[p];
            acc = acc | (old[p*8 +: 8] ^ t_q[p]);
          end
        rb[k] = ~acc;
        lat += we ? 1 : 2;
      end
    end
    if (word) tag = {tag, " R8"};
    tag = {"R2 ", tag};
    do_acc(we, word, addr, pg, wd, rd, nb);
    check(nb == lat, {"R10 busy length ", tag}, 32'(nb), 32'(lat));
    if (we) begin
      for (int k = 0; k < n; k++)
        check(get(a[k]) == expw[k], {tag, " plane bytes"}, get(a[k]), expw[k]);
      check(disp_chg[pg] == 1'b1, "R9 disp_chg set", 32'(disp_chg), 32'(pg ? 2 : 1));
    end else begin
      exprd = word ? {rb[1], rb[0]} : {8'h00, rb[0]};
      check(rd == exprd, {tag, " read data"}, 32'(rd), 32'(exprd));
    end
  endtask

  task automatic ack_all;
    @(negedge clk); disp_ack = 2'b11;
    @(negedge clk); disp_ack = 2'b00;
    check(disp_chg == 2'b00, "R9 disp_ack clears", 32'(disp_chg), 32'd0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int seed;
    logic [15:0] rd;
    int nb;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && rvalid == 0, "R1 busy/rvalid at reset", {busy, rvalid}, 0);
    check(mem_re == 0 && mem_we == 0 && dirty_we == 0, "R1 strobes at reset",
          {mem_re, mem_we, dirty_we}, 0);
    check(disp_chg == 0, "R1 disp_chg at reset", 32'(disp_chg), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(busy == 0 && disp_chg == 0, "R1 idle after release", {busy, disp_chg}, 0);
    // R1 mode 0x00 after reset: plain read of plane 2
    run(0, 0, {2'd2, 15'h0040}, 0, 16'h0);

    set_tile(0, 8'h12); set_tile(1, 8'h34); set_tile(2, 8'h56); set_tile(3, 8'h78);
    // R3 tile stamp ignores CPU data
    set_mode(8'h80);
    run(1, 0, {2'd0, 15'h0100}, 0, 16'hFFAB);
    // R5 compare hits on freshly stamped byte: expect 0xFF
    run(0, 0, {2'd0, 15'h0100}, 0, 16'h0);
    // R8 word wrap at top offset, page 1
    run(1, 1, {2'd0, 15'h7FFF}, 1, 16'h5A5A);
    run(0, 1, {2'd0, 15'h7FFF}, 1, 16'h0);
    // R3 / R5 all planes excluded
    set_mode(8'h8F);
    run(1, 1, {2'd0, 15'h0200}, 0, 16'h1234);
    run(0, 0, {2'd0, 15'h0201}, 0, 16'h0);
    // R4 blend and R6 plain read in blend mode
    set_mode(8'hC5);
    run(1, 0, {2'd0, 15'h0300}, 1, 16'h00F0);
    run(0, 1, {2'd3, 15'h0300}, 1, 16'h0);
    // R7 inactive write
    set_mode(8'h00);
    run(1, 1, {2'd1, 15'h0400}, 0, 16'hC3A5);
    ack_all();

    for (int i = 0; i < 400; i++) begin
      int r;
      logic [14:0] ofs;
      if ($urandom % 8 == 0) begin
        r = $urandom % 3;
        set_mode((r == 0 ? 8'h00 : (r == 1 ? 8'h80 : 8'hC0)) | 8'($urandom % 16));
      end
      if ($urandom % 10 == 0) set_tile($urandom % 4, 8'($urandom));
      ofs = ($urandom % 8 == 0) ? 15'h7FFF : 15'($urandom % 32);
      run(1'($urandom), 1'($urandom), {2'($urandom), ofs}, 1'($urandom), 16'($urandom));
      if ($urandom % 25 == 0) ack_all();
    end
    do_acc(0, 0, 17'h0, 0, 16'h0, rd, nb);
    done = 1;
    finish_run();
  end
endmodule